// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Output

This block is a 32-bit up-counter for timing and waveform generation. Software programs it through a small word-addressed register port. It holds a control word, a direct counter value, a load value for reloads, a reload-trigger location and a compare value. The counter advances on every clock while running, or once every 2^(N+1) clocks when the prescaler is enabled. When it wraps past all ones, it either reloads from the load register and keeps running, or stops at zero.

Two one-cycle strobes report events. `ovf_evt` marks each wrap of the counter. `mat_evt` marks each time the counter steps onto the compare value. A single output pin turns these events into a waveform. The pin can toggle on each selected event, which gives PWM when both wrap and match are selected. It can instead flash the inverse of a static idle level for one cycle. When the pin is configured as an input, its level is frozen and its output enable is dropped.

Register map (`wr_addr`/`rd_addr`): 0 control, 1 counter, 2 load, 3 reload trigger (reads 0), 4 compare. Any other address reads 0. Control bits: [0] run, [1] auto-reload, [4:2] prescale exponent N, [5] prescale enable, [6] compare enable, [7] idle level, [9:8] capture mode (stored only), [11:10] output event select, [12] toggle (1) / pulse (0), [13] capture select (stored only), [14] pin direction (1 = input).

Top module: `cmp_timer_pwm`

## Requirements
- R1: While run is 1 and the prescaler is off, the counter (read at address 1) rises by one on every clock. While run is 0 it holds its value and no event strobe is raised.
- R2: When the counter wraps from 0xFFFFFFFF with auto-reload set, it takes the load register value, keeps running, and `ovf_evt` is high for exactly the following cycle.
- R3: When the counter wraps with auto-reload clear, the counter becomes 0, control bit 0 reads back as 0, and `ovf_evt` pulses once.
- R4: With prescale enable set, the counter advances once every 2^(N+1) clocks, where N is control bits [4:2].
- R5: With compare enable set, `mat_evt` is high for the cycle in which the counter has just stepped onto the compare register value. With compare enable clear, `mat_evt` stays low.
- R6: Output event select (control bits [11:10]) works as follows. 0 gives no pin events. 1 gives pin events on wraps only. 2 gives pin events on wraps and matches. 3 behaves like 0.
- R7: With control bit 12 set, each pin event inverts the pin. With it clear, each pin event drives the inverse of the idle level for exactly one cycle.
- R8: While run is 0 or event select is 0 or 3, the pin settles to the idle level (control bit 7) one cycle later.
- R9: A write to address 3, whatever its data, copies the load register into the counter. A write to address 1 or 3 in a cycle where a count step is due replaces that step, and no event is raised.
- R10: With control bit 14 set, `pin_oe` is 0 and `pin_out` holds its level. With it clear, `pin_oe` is 1.
- R11: After reset, every register reads 0, `pin_out` is 0 and `pin_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ovf_evt | output | 1 | One-cycle strobe after a counter wrap |
| mat_evt | output | 1 | One-cycle strobe after the counter reaches the compare value |
| pin_out | output | 1 | Waveform pin level |
| pin_oe | output | 1 | Pin output enable (1 = pin driven) |

## Verification
The bench places the counter a few steps below all ones so that wraps and matches recur every few dozen cycles. It sweeps event select through all four codes in toggle and pulse form. A design that stops counting, or stops and clears when it should reload, shows up as a counter mismatch within one cycle, and so does an off-by-one in the prescale divider or the compare point. It also writes the counter while a step is due and flips the pin to input in the middle of a waveform. A design that lets the step slip through, or that keeps toggling a pin set as input, would drift from the model at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PV_W   = 3;
  localparam int unsigned CTRL_W = 15;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLTRG = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP   = 3'd4;

  typedef enum logic [1:0] {
    EVSEL_NONE = 2'd0,
    EVSEL_WRAP = 2'd1,
    EVSEL_BOTH = 2'd2,
    EVSEL_RSVD = 2'd3
  } evsel_e;

  typedef struct packed {
    logic            pin_in;
    logic            cap_sel;
    logic            toggle;
    evsel_e          evsel;
    logic [1:0]      cap_mode;
    logic            idle_lvl;
    logic            cmp_en;
    logic            pre_en;
    logic [PV_W-1:0] pre_exp;
    logic            auto_rl;
    logic            run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic [EXP_W-1:0] pre_exp,
  output logic             tick
);
  localparam int unsigned CNT_W = 2 ** EXP_W;

  logic [CNT_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] term;

  // terminal count is 2^(exp+1)-1: ones in bit positions 0..exp
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      term[i] = (i <= int'(pre_exp));
    end
  end

  always_comb begin
    tick  = run & (~pre_en | (div_q == term));
    div_d = div_q;
    if (!(run && pre_en)) begin
      div_d = '0;
    end else if (tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic         wr_reload,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_val,
  input  logic         cmp_en,
  input  logic         auto_rl,
  output logic [W-1:0] cnt,
  output logic         wrap_now,
  output logic         match_now,
  output logic         ovf_evt,
  output logic         mat_evt
);
  logic [W-1:0] cnt_q, cnt_d, cnt_inc;
  logic         at_max, step;
  logic         ovf_q, mat_q;

  always_comb begin
    at_max    = &cnt_q;
    cnt_inc   = cnt_q + 1'b1;
    step      = tick & ~wr_cnt & ~wr_reload;
    wrap_now  = step & at_max;
    match_now = step & cmp_en & ~at_max & (cnt_inc == cmp_val);
    if (wr_cnt) begin
      cnt_d = wr_data;
    end else if (wr_reload) begin
      cnt_d = load_val;
    end else if (wrap_now) begin
      cnt_d = auto_rl ? load_val : '0;
    end else if (step) begin
      cnt_d = cnt_inc;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      mat_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= wrap_now;
      mat_q <= match_now;
    end
  end

  assign cnt     = cnt_q;
  assign ovf_evt = ovf_q;
  assign mat_evt = mat_q;
endmodule

// File: rtl/tmr_outgen.sv
module tmr_outgen
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_in,
  input  logic   run,
  input  evsel_e evsel,
  input  logic   toggle,
  input  logic   idle_lvl,
  input  logic   wrap_now,
  input  logic   match_now,
  output logic   pin
);
  logic pin_q, pin_d;
  logic active, ev;

  always_comb begin
    active = run & ((evsel == EVSEL_WRAP) | (evsel == EVSEL_BOTH));
    ev     = (wrap_now & active) | (match_now & active & (evsel == EVSEL_BOTH));
    if (pin_in) begin
      pin_d = pin_q;
    end else if (!active) begin
      pin_d = idle_lvl;
    end else if (toggle) begin
      pin_d = pin_q ^ ev;
    end else begin
      pin_d = idle_lvl ^ ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign pin = pin_q;
endmodule

// File: rtl/cmp_timer_pwm.sv
module cmp_timer_pwm
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf_evt,
  output logic              mat_evt,
  output logic              pin_out,
  output logic              pin_oe
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] load_q, load_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic [DATA_W-1:0] cnt;
  logic              tick, wrap_now, match_now;
  logic              wr_ctrl, wr_cnt, wr_load, wr_rl, wr_cmp;

  always_comb begin
    wr_ctrl = wr_en & (wr_addr == A_CTRL);
    wr_cnt  = wr_en & (wr_addr == A_COUNT);
    wr_load = wr_en & (wr_addr == A_LOAD);
    wr_rl   = wr_en & (wr_addr == A_RLTRG);
    wr_cmp  = wr_en & (wr_addr == A_CMP);
  end

  tmr_prescaler #(.EXP_W(PV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .pre_en  (ctrl_q.pre_en),
    .pre_exp (ctrl_q.pre_exp),
    .tick    (tick)
  );

  tmr_counter #(.W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_cnt    (wr_cnt),
    .wr_reload (wr_rl),
    .wr_data   (wr_data),
    .load_val  (load_q),
    .cmp_val   (cmp_q),
    .cmp_en    (ctrl_q.cmp_en),
    .auto_rl   (ctrl_q.auto_rl),
    .cnt       (cnt),
    .wrap_now  (wrap_now),
    .match_now (match_now),
    .ovf_evt   (ovf_evt),
    .mat_evt   (mat_evt)
  );

  tmr_outgen u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (ctrl_q.pin_in),
    .run       (ctrl_q.run),
    .evsel     (ctrl_q.evsel),
    .toggle    (ctrl_q.toggle),
    .idle_lvl  (ctrl_q.idle_lvl),
    .wrap_now  (wrap_now),
    .match_now (match_now),
    .pin       (pin_out)
  );

  // next state of the software-visible registers
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
    end else if (wrap_now && !ctrl_q.auto_rl) begin
      ctrl_d.run = 1'b0;
    end
    load_d = wr_load ? wr_data : load_q;
    cmp_d  = wr_cmp  ? wr_data : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      cmp_q  <= cmp_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      A_COUNT: rd_data = cnt;
      A_LOAD:  rd_data = load_q;
      A_CMP:   rd_data = cmp_q;
      default: rd_data = '0;
    endcase
  end

  assign pin_oe = ~ctrl_q.pin_in;
endmodule

// File: rtl/cmp_timer_pwm_chk.sv
module cmp_timer_pwm_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CTRL_W-1:0] ctrl_bits,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] load_q,
  input logic [DATA_W-1:0] cmp_q,
  input logic              ovf_evt,
  input logic              mat_evt,
  input logic              pin_out
);
  logic run, arl, idle, pin_in;
  assign run    = ctrl_bits[0];
  assign arl    = ctrl_bits[1];
  assign idle   = ctrl_bits[7];
  assign pin_in = ctrl_bits[14];

  AST_NO_EVT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (!ovf_evt && !mat_evt)); // R1

  AST_RELOAD_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && $past(arl) && !$past(wr_en)) |-> (cnt == $past(load_q))); // R2

  AST_OVF_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !$past(arl) && !$past(wr_en)) |-> (cnt == '0 && !run)); // R3

  AST_MATCH_AT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    mat_evt |-> (cnt == $past(cmp_q))); // R5

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run && !pin_in) |-> (pin_out == $past(idle))); // R8

  AST_PIN_HOLD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_in) |-> (pin_out == $past(pin_out))); // R10
endmodule

bind cmp_timer_pwm cmp_timer_pwm_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .ctrl_bits (ctrl_q),
  .cnt       (cnt),
  .load_q    (load_q),
  .cmp_q     (cmp_q),
  .ovf_evt   (ovf_evt),
  .mat_evt   (mat_evt),
  .pin_out   (pin_out)
);

// File: tb/cmp_timer_pwm_tb_top.sv
`timescale 1ns/100ps
module cmp_timer_pwm_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        ovf_evt, mat_evt, pin_out, pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  cmp_timer_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ovf_evt(ovf_evt), .mat_evt(mat_evt), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [14:0] m_ctrl;
  longint      m_cnt, m_load, m_cmp;
  int          m_pc;
  bit          m_ovf, m_mat, m_pin;
  localparam longint MAXV = 64'hFFFF_FFFF;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_load = 0; m_cmp = 0; m_pc = 0;
      m_ovf = 0; m_mat = 0; m_pin = 0;
    end else begin
      bit st, pe, tk, skip, wc, wr, ev, act;
      int lim, sel;
      longint nc;
      st  = m_ctrl[0];
      pe  = m_ctrl[5];
      lim = (1 << (int'(m_ctrl[4:2]) + 1)) - 1;
      tk  = st && (!pe || m_pc == lim);
      if (st && pe) m_pc = tk ? 0 : m_pc + 1; else m_pc = 0;
      wc   = wr_en && wr_addr == 1;
      wr   = wr_en && wr_addr == 3;
      skip = !tk || wc || wr;
      m_ovf = !skip && m_cnt == MAXV;
      m_mat = !skip && m_ctrl[6] && m_cnt != MAXV && (m_cnt + 1) == m_cmp;
      if (wc) nc = longint'(wr_data);
      else if (wr) nc = m_load;
      else if (m_ovf) nc = m_ctrl[1] ? m_load : 0;
      else if (!skip) nc = m_cnt + 1;
      else nc = m_cnt;
      sel = int'(m_ctrl[11:10]);
      act = st && (sel == 1 || sel == 2);
      ev  = act && (m_ovf || (m_mat && sel == 2));
      if (!m_ctrl[14]) begin
        if (!act) m_pin = m_ctrl[7];
        else if (m_ctrl[12]) m_pin = m_pin ^ ev;
        else m_pin = m_ctrl[7] ^ ev;
      end
      if (wr_en && wr_addr == 0) m_ctrl = wr_data[14:0];
      else if (m_ovf && !m_ctrl[1]) m_ctrl[0] = 1'b0;
      if (wr_en && wr_addr == 2) m_load = longint'(wr_data);
      if (wr_en && wr_addr == 4) m_cmp = longint'(wr_data);
      m_cnt = nc;
    end
  end

  function automatic longint m_read(input logic [2:0] a);
    case (a)
      3'd0: return longint'(m_ctrl);
      3'd1: return m_cnt;
      3'd2: return m_load;
      3'd4: return m_cmp;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 rd_data", longint'(rd_data), m_read(rd_addr));
      chk("R2 ovf_evt", longint'(ovf_evt), longint'(m_ovf));
      chk("R5 mat_evt", longint'(mat_evt), longint'(m_mat));
      chk("R7 pin_out", longint'(pin_out), longint'(m_pin));
      chk("R10 pin_oe", longint'(pin_oe), longint'(!m_ctrl[14]));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; wr_data = 0;
  endtask

  task automatic idle_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] mk(input bit pin_in, input bit tog, input int sel,
      input bit idle, input bit ce, input bit pe, input int pv, input bit ar, input bit st);
    return {17'd0, pin_in, 1'b0, tog, 2'(sel), 2'b00, idle, ce, pe, 3'(pv), ar, st};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  int pin_edges;
  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 3'd1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R11 reset state
    chk("R11 count", longint'(rd_data), 0);
    chk("R11 pin_out", longint'(pin_out), 0);
    chk("R11 pin_oe", longint'(pin_oe), 1);
    rd_addr = 3'd0; #0.1;
    chk("R11 ctrl", longint'(rd_data), 0);
    rd_addr = 3'd1;
    @(posedge clk); #1;

    // R1 plain counting: 10 steps
    wr(0, mk(0,0,0,0,0,0,0,0,1));
    idle_cyc(10);
    chk("R1 count after 10", longint'(rd_data), 10);
    // stopped: holds
    wr(0, mk(0,0,0,0,0,0,0,0,0));
    idle_cyc(5);
    chk("R1 hold when stopped", longint'(rd_data), 11);

    // R4 prescale N=1 (divide by 4)
    wr(1, 0);
    wr(0, mk(0,0,0,0,0,1,1,0,1));
    idle_cyc(16);
    chk("R4 div4 count", longint'(rd_data), 4);
    wr(0, 0);

    // R3 wrap without auto-reload
    wr(1, 32'hFFFF_FFFE);
    wr(0, mk(0,0,0,0,0,0,0,0,1));
    idle_cyc(3);
    chk("R3 count cleared", longint'(rd_data), 0);
    rd_addr = 3'd0; #0.1;
    chk("R3 run cleared", longint'(rd_data[0]), 0);
    rd_addr = 3'd1;

    // R2 wrap with auto-reload
    wr(2, 32'd100);
    wr(1, 32'hFFFF_FFFF);
    wr(0, mk(0,0,0,0,0,0,0,1,1));
    idle_cyc(3);
    chk("R2 reloaded and running", longint'(rd_data), 102);

    // R9 reload trigger copies load regardless of data
    wr(3, 32'h1234_5678);
    chk("R9 reload trigger", longint'(rd_data), 100);
    // R9 direct write beats the due step
    wr(1, 32'd7);
    chk("R9 write beats step", longint'(rd_data), 7);
    wr(0, 0);

    // R5 R6 R7 waveform sweep near the top of the range
    wr(2, 32'hFFFF_FFF0);
    wr(4, 32'hFFFF_FFF8);
    wr(1, 32'hFFFF_FFF0);
    for (int sel = 0; sel < 4; sel++) begin
      for (int tog = 0; tog < 2; tog++) begin
        wr(0, mk(0, 1'(tog), sel, 1'(sel[0]), 1, 0, 0, 1, 1));
        idle_cyc(40);
      end
    end
    // R6 toggle on both events: count pin edges over 64 cycles
    wr(0, mk(0,1,2,0,1,0,0,1,1));
    pin_edges = 0;
    for (int i = 0; i < 64; i++) begin
      logic p;
      p = pin_out;
      @(posedge clk); #1;
      if (pin_out != p) pin_edges++;
    end
    chk("R6 both-event toggles in 64 cycles", longint'(pin_edges), 8);
    // R10 pin as input freezes the level
    wr(0, mk(1,1,2,0,1,1,0,1,1));
    idle_cyc(60);
    chk("R10 pin_oe low", longint'(pin_oe), 0);
    // R8 stopped with idle level 1
    wr(0, mk(0,1,2,1,1,0,0,1,0));
    idle_cyc(2);
    chk("R8 idle level when stopped", longint'(pin_out), 1);
    // R5 compare disabled: prescaled run with pulse output
    wr(0, mk(0,0,1,0,0,1,2,1,1));
    idle_cyc(200);
    wr(3, 0);
    idle_cyc(5);
    finish_run();
  end
endmodule